// File: doc/BRIEF.md
# Boot-Time Serial EEPROM Configuration Reader

This block fetches a small configuration record from a three-wire serial EEPROM once after every reset. It talks to the memory over a clock output and one bidirectional data line that it shares with the memory. When the active-low external-memory select is low in the first cycle after reset, the block drives a fixed read command. The command is a start bit, the read opcode and a word address of zero. The block then lets go of the data line and clocks in 48 bits from the memory, which advances its own address from word to word. The first sampled bit is the memory's dummy zero and is discarded.

From the three words it keeps the ganged power-mode flag, the vendor ID and the product ID, and it pulses `done`. After the transfer both pin enables stay low, so other logic can use the EEPROM. When the select is high, the pins are never driven. In that case the IDs take their parameter defaults and the ganged flag is taken from the level on the shared data pin, which then serves as a strap.

Top module: `ee_cfg_reader`

## Requirements
- R1: The mode is chosen from `ext_mem_n` in the first clock cycle after reset: low starts a read, high selects defaults. Exactly one read or default load happens per reset, and later changes on `ext_mem_n` have no effect.
- R2: In read mode the block drives the 9-bit command 1,1,0,0,0,0,0,0,0, one bit per serial clock period, first bit first. The driven value does not change while the clock rises.
- R3: The serial clock starts low. Each period is HALF_DIV core cycles low followed by HALF_DIV core cycles high. There are 57 periods, and the clock enable is high for exactly 114×HALF_DIV cycles.
- R4: The data enable falls at the rising clock edge of the ninth period, which carries the last address bit. It never rises again before reset, and the block never drives data while the memory does.
- R5: The data line is sampled on each falling clock edge from the ninth period onward. The first sample is the dummy bit and is dropped; the next 48 samples form words 0, 1 and 2, each MSB first.
- R6: `ganged` equals bit 14 of word 0, `vendor_id` equals word 1 and `product_id` equals word 2.
- R7: After the final falling edge, the clock enable and the data enable stay low until the next reset.
- R8: `done` is high for exactly one cycle, the cycle after the last falling edge in read mode or the second cycle after reset in default mode. The outputs become valid in that cycle and hold afterwards.
- R9: In default mode the clock and data enables never rise, `vendor_id`/`product_id` take DEF_VID/DEF_PID, and `ganged` takes the level on `ee_dat_i`.
- R10: During reset and until `done`, all enables, `done`, `ganged` and both IDs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mem_n | input | 1 | Low: read the EEPROM; high: use defaults and the strap |
| ee_clk_o | output | 1 | Serial clock to the EEPROM |
| ee_clk_oe | output | 1 | Output enable for the serial clock pad |
| ee_dat_i | input | 1 | Level seen on the shared data pad |
| ee_dat_o | output | 1 | Value driven on the data pad |
| ee_dat_oe | output | 1 | Output enable for the data pad |
| ganged | output | 1 | Ganged power-mode flag |
| vendor_id | output | 16 | Vendor ID |
| product_id | output | 16 | Product ID |
| done | output | 1 | One-cycle pulse when the outputs become valid |

## Verification
The assertions check the following on every cycle: the data pad is never driven without the clock enable, the command bit is stable across each rising clock edge, `done` lasts one cycle and never returns within a reset, and both pad enables and all three results stay frozen once `done` has been seen. Some behaviour can only be shown by the bench's scenarios. These include the exact command bits and the release point measured by a memory model on the clock line, and the cycle-exact clock waveform. They also include the picking of bit 14 out of a noisy word 0, the strap value in default mode, and the absence of a restart when `ext_mem_n` toggles after completion.

// File: rtl/ee_cfg_reader_pkg.sv
package ee_cfg_reader_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_LATCH,
    ST_HOLD
  } rd_state_t;

  localparam int WORD_W    = 16;
  localparam int NUM_WORDS = 3;
  localparam int DATA_BITS = WORD_W * NUM_WORDS;
  localparam int CMD_BITS  = 9;
  localparam logic [CMD_BITS-1:0] CMD_WORD = 9'b1_10_000000;
  localparam int GANG_BIT  = 14;
endpackage

// File: rtl/ee_cfg_tick.sv
module ee_cfg_tick #(
  parameter int DIV = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == CW'(DIV - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!en)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ee_cfg_seq.sv
module ee_cfg_seq
  import ee_cfg_reader_pkg::*;
#(
  parameter int HALF_DIV = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_mem_n,
  input  logic tick,
  output logic run,
  output logic sclk,
  output logic dat_o,
  output logic dat_oe,
  output logic smp_en,
  output logic cap_en,
  output logic byp
);
  localparam int HALF_TOTAL = 2 * (CMD_BITS + DATA_BITS);
  localparam int HW         = $clog2(HALF_TOTAL);
  localparam int REL_HALF   = 2 * CMD_BITS - 1;
  localparam int FIRST_SMP  = 2 * CMD_BITS + 1;

  rd_state_t     st_q, st_d;
  logic [HW-1:0] h_q, h_d;
  logic          byp_q, byp_d;
  logic [HW-2:0] period;
  logic          cmd_bit;

  assign period = h_q[HW-1:1];
  assign run    = (st_q == ST_SHIFT);
  assign sclk   = run && h_q[0];
  assign dat_oe = run && (h_q < HW'(REL_HALF));
  assign dat_o  = dat_oe && cmd_bit;
  assign smp_en = tick && h_q[0] && (h_q >= HW'(FIRST_SMP));
  assign cap_en = (st_q == ST_LATCH);
  assign byp    = byp_q;

  always_comb begin
    cmd_bit = 1'b0;
    for (int i = 0; i < CMD_BITS; i++) begin
      if (int'(period) == i) cmd_bit = CMD_WORD[CMD_BITS-1-i];
    end
  end

  always_comb begin
    st_d  = st_q;
    h_d   = h_q;
    byp_d = byp_q;
    unique case (st_q)
      ST_IDLE: begin
        byp_d = ext_mem_n;
        st_d  = ext_mem_n ? ST_LATCH : ST_SHIFT;
        h_d   = '0;
      end
      ST_SHIFT: begin
        if (tick) begin
          h_d = h_q + 1'b1;
          if (h_q == HW'(HALF_TOTAL - 1)) begin
            st_d = ST_LATCH;
            h_d  = '0;
          end
        end
      end
      ST_LATCH: st_d = ST_HOLD;
      default:  st_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      h_q   <= '0;
      byp_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      h_q   <= h_d;
      byp_q <= byp_d;
    end
  end
endmodule

// File: rtl/ee_cfg_capture.sv
module ee_cfg_capture
  import ee_cfg_reader_pkg::*;
#(
  parameter logic [WORD_W-1:0] DEF_VID = 16'hA5C3,
  parameter logic [WORD_W-1:0] DEF_PID = 16'h0B1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic              din,
  input  logic              cap_en,
  input  logic              byp,
  output logic              ganged,
  output logic [WORD_W-1:0] vid,
  output logic [WORD_W-1:0] pid,
  output logic              done
);
  localparam int GANG_POS = 2 * WORD_W + GANG_BIT;

  logic [DATA_BITS-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sr_q <= '0;
    else if (smp_en) sr_q <= {sr_q[DATA_BITS-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ganged <= 1'b0;
      vid    <= '0;
      pid    <= '0;
    end else if (cap_en) begin
      ganged <= byp ? din     : sr_q[GANG_POS];
      vid    <= byp ? DEF_VID : sr_q[2*WORD_W-1:WORD_W];
      pid    <= byp ? DEF_PID : sr_q[WORD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= cap_en;
  end
endmodule

// File: rtl/ee_cfg_reader.sv
module ee_cfg_reader
  import ee_cfg_reader_pkg::*;
#(
  parameter int                HALF_DIV = 25,
  parameter logic [WORD_W-1:0] DEF_VID  = 16'hA5C3,
  parameter logic [WORD_W-1:0] DEF_PID  = 16'h0B1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mem_n,
  output logic              ee_clk_o,
  output logic              ee_clk_oe,
  input  logic              ee_dat_i,
  output logic              ee_dat_o,
  output logic              ee_dat_oe,
  output logic              ganged,
  output logic [WORD_W-1:0] vendor_id,
  output logic [WORD_W-1:0] product_id,
  output logic              done
);
  logic run, tick, smp_en, cap_en, byp;

  ee_cfg_tick #(.DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(run), .tick(tick)
  );

  ee_cfg_seq #(.HALF_DIV(HALF_DIV)) u_seq (
    .clk(clk), .rst_n(rst_n), .ext_mem_n(ext_mem_n), .tick(tick),
    .run(run), .sclk(ee_clk_o), .dat_o(ee_dat_o), .dat_oe(ee_dat_oe),
    .smp_en(smp_en), .cap_en(cap_en), .byp(byp)
  );

  assign ee_clk_oe = run;

  ee_cfg_capture #(.DEF_VID(DEF_VID), .DEF_PID(DEF_PID)) u_cap (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .din(ee_dat_i),
    .cap_en(cap_en), .byp(byp), .ganged(ganged), .vid(vendor_id),
    .pid(product_id), .done(done)
  );
endmodule

// File: rtl/ee_cfg_reader_chk.sv
module ee_cfg_reader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ee_clk_o,
  input logic        ee_clk_oe,
  input logic        ee_dat_o,
  input logic        ee_dat_oe,
  input logic        ganged,
  input logic [15:0] vendor_id,
  input logic [15:0] product_id,
  input logic        done
);
  logic seen_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    seen_done <= 1'b0;
    else if (done) seen_done <= 1'b1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R10: assert (!ee_clk_oe && !ee_dat_oe && !done &&
                                      !ganged && vendor_id == 16'h0 && product_id == 16'h0);
    end
  end

  assert_data_needs_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ee_dat_oe |-> ee_clk_oe);

  assert_cmd_stable_at_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_dat_oe && $rose(ee_clk_o)) |-> $stable(ee_dat_o));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_second_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seen_done |-> !done);

  assert_pins_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seen_done |-> (!ee_clk_oe && !ee_dat_oe));

  assert_results_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seen_done |-> ($stable(ganged) && $stable(vendor_id) && $stable(product_id)));
endmodule

bind ee_cfg_reader ee_cfg_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ee_clk_o(ee_clk_o), .ee_clk_oe(ee_clk_oe),
  .ee_dat_o(ee_dat_o), .ee_dat_oe(ee_dat_oe), .ganged(ganged),
  .vendor_id(vendor_id), .product_id(product_id), .done(done)
);

// File: tb/ee_cfg_reader_tb.sv
module ee_cfg_reader_tb;
  localparam int D      = 25;
  localparam int LAST_N = 114 * D;
  localparam logic [15:0] DVID = 16'hA5C3;
  localparam logic [15:0] DPID = 16'h0B1E;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        ext_mem_n;
  logic        ee_clk_o, ee_clk_oe, ee_dat_o, ee_dat_oe, ee_dat_i;
  logic        ganged, done;
  logic [15:0] vendor_id, product_id;

  int compared = 0;
  int mismatched = 0;
  int edges;
  int n, h, done_n;
  bit model_on = 1'b0;
  logic        byp_mode, strap;
  logic [15:0] w0, w1, w2;
  logic [47:0] data48;
  int          rcount;
  logic        eep_drv, eep_bit;
  logic [8:0]  host_bits;
  logic        e_coe, e_clk, e_doe, e_g;
  logic [15:0] e_vid, e_pid;

  assign ee_dat_i = ee_dat_oe ? ee_dat_o : (eep_drv ? eep_bit : strap);

  ee_cfg_reader #(.HALF_DIV(D), .DEF_VID(DVID), .DEF_PID(DPID)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_mem_n(ext_mem_n),
    .ee_clk_o(ee_clk_o), .ee_clk_oe(ee_clk_oe), .ee_dat_i(ee_dat_i),
    .ee_dat_o(ee_dat_o), .ee_dat_oe(ee_dat_oe), .ganged(ganged),
    .vendor_id(vendor_id), .product_id(product_id), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  // EEPROM model: reacts to rising edges of the generated clock
  always @(posedge ee_clk_o) begin
    rcount = rcount + 1;
    if (rcount <= 9) host_bits = {host_bits[7:0], ee_dat_o};
    if (rcount >= 9) begin
      eep_drv = 1'b1;
      if (rcount == 9)       eep_bit = 1'b0;
      else if (rcount <= 57) eep_bit = data48[57-rcount];
    end
  end

  // Cycle-by-cycle reference model
  always @(negedge clk) begin
    if (model_on) begin
      n      = edges - 1;
      done_n = byp_mode ? 1 : LAST_N + 1;
      h      = (n >= 0) ? n / D : 0;
      e_coe  = !byp_mode && (n >= 0) && (n < LAST_N);
      e_clk  = e_coe && (h % 2 == 1);
      e_doe  = e_coe && (h < 17);
      e_g    = 1'b0; e_vid = 16'h0; e_pid = 16'h0;
      if (n >= done_n) begin
        e_g   = byp_mode ? strap : w0[14];
        e_vid = byp_mode ? DVID : w1;
        e_pid = byp_mode ? DPID : w2;
      end
      chk("R3 clock enable", ee_clk_oe, e_coe);
      chk("R3 clock level", ee_clk_o, e_clk);
      chk("R4/R7/R9 data enable", ee_dat_oe, e_doe);
      if (e_doe) begin
        chk("R2 command bit", ee_dat_o, (h / 2) < 2);
        chk("R4 no contention", eep_drv, 1'b0);
      end
      chk("R8 done pulse", done, (n == done_n));
      chk("R6/R9 ganged", ganged, e_g);
      chk("R6/R9 vendor id", vendor_id, e_vid);
      chk("R6/R9 product id", product_id, e_pid);
    end
  end

  task automatic do_run(input logic byp, input logic [15:0] a, input logic [15:0] b,
                        input logic [15:0] c, input logic s);
    @(negedge clk);
    model_on = 1'b0;
    rst_n    = 1'b0;
    w0 = a; w1 = b; w2 = c; data48 = {a, b, c};
    strap = s; ext_mem_n = byp; byp_mode = byp;
    rcount = 0; eep_drv = 1'b0; eep_bit = 1'b0; host_bits = 9'h0;
    repeat (3) @(negedge clk);
    chk("R10 reset clk enable", ee_clk_oe, 1'b0);
    chk("R10 reset data enable", ee_dat_oe, 1'b0);
    chk("R10 reset done", done, 1'b0);
    chk("R10 reset ids", {vendor_id, product_id}, 32'h0);
    chk("R10 reset ganged", ganged, 1'b0);
    model_on = 1'b1;
    rst_n    = 1'b1;
    repeat (byp ? 4 : LAST_N + 4) @(negedge clk);
    ext_mem_n = ~ext_mem_n;   // R1: must not restart anything
    repeat (150) @(negedge clk);
    ext_mem_n = ~ext_mem_n;
    repeat (150) @(negedge clk);
    if (!byp) begin
      chk("R2 command sequence", host_bits, 9'b110000000);
      chk("R3/R5 rising edge count", rcount, 57);
    end else begin
      chk("R9 clock never rose", rcount, 0);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    ext_mem_n = 1'b0;
    strap = 1'b0;
    eep_drv = 1'b0;
    eep_bit = 1'b0;
    rcount = 0;
    host_bits = 9'h0;
    byp_mode = 1'b0;
    w0 = '0; w1 = '0; w2 = '0; data48 = '0;
    do_run(1'b0, 16'h4000, 16'hBEEF, 16'h1357, 1'b0);
    do_run(1'b0, 16'hBFFF, 16'h8001, 16'h7FFE, 1'b1);
    do_run(1'b1, 16'h4000, 16'h1111, 16'h2222, 1'b1);
    do_run(1'b1, 16'hFFFF, 16'h3333, 16'h4444, 1'b0);
    do_run(1'b0, 16'h0000, 16'h0000, 16'hFFFF, 1'b1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule